// File: doc/BRIEF.md
# Codec Control Register File with SPI and I2C Access

This block holds the control settings of an audio codec in thirteen 9-bit registers and presents all of them at once as one packed parallel word for the rest of the chip. A host reaches the registers through one of two serial ports that share the same three pins: a 3-wire SPI-style port that only writes, and a 2-wire I2C slave port that can write and read back. A static mode pin chooses the port. The serial pins are sampled with the block's own clock, so the serial clocks must run well below it.

Every register has a fixed value after reset. Writing any value to the software-reset address puts every register back to that value. For the two left/right pairs of volume registers, a write with data bit 8 set also copies the same 9-bit word into the partner register. This saves a second write when both channels must change together.

Top module: `codec_ctl_regs`

## Requirements
- R1: `if_mode` = 1 selects the SPI port and `if_mode` = 0 selects the I2C port. Traffic on the unselected port changes no register and gets no acknowledge. `sda_pull` is never asserted while `if_mode` = 1.
- R2: An SPI frame is written while `csel` is low. `sdi` is sampled on each rising edge of `sck`, MSB first. Bits 15..9 are the register address and bits 8..0 are the data. The write takes effect when `csel` rises. A frame with a bit count other than 16 is discarded.
- R3: In I2C mode the slave answers to device address 7'b0011010 while `csel` is low and to 7'b0011011 while `csel` is high. Any other device address gets no acknowledge, and the transfer that follows is ignored.
- R4: An I2C write is three bytes, each acknowledged by pulling SDA low in the ninth clock. The bytes are the device address with R/W = 0, then {address[6:0], data[8]}, then data[7:0]. The register updates once the third byte has arrived. Any byte after the third is not acknowledged and has no effect.
- R5: An I2C read has two parts. First the device address with R/W = 0 and the {address, x} byte are sent. Then a repeated start and the device address with R/W = 1 follow. The slave returns data[7:0], MSB first. After a master acknowledge it returns a second byte that is {7'b0, data[8]}.
- R6: After reset the values are 0x097 at 0x00 and 0x01, 0x079 at 0x02 and 0x03, 0x00A at 0x04, 0x008 at 0x05, 0x09F at 0x06, 0x00A at 0x07, 0x07B at 0x10 and 0x032 at 0x11. Addresses 0x08, 0x09 and 0x12 reset to 0.
- R7: A write of any data to address 0x0F returns every register to its R6 value.
- R8: A write to 0x00, 0x01, 0x02 or 0x03 with data bit 8 set stores the same word at the address with bit 0 flipped as well. With bit 8 clear, only the addressed register changes.
- R9: Writes to any address other than 0x00..0x09, 0x0F and 0x10..0x12 are discarded. I2C reads of any address other than 0x00..0x09 and 0x10..0x12 return 0, and 0x0F also reads as 0.
- R10: `ctl_word` holds slot k in bits [9k+8:9k]. Slots 0..9 are addresses 0x00..0x09 and slots 10..12 are addresses 0x10..0x12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_mode | input | 1 | Port select: 1 = SPI, 0 = I2C |
| csel | input | 1 | SPI chip select (active low), or I2C device-address LSB |
| sck | input | 1 | SPI bit clock, or I2C SCL |
| sdi | input | 1 | SPI data in, or I2C SDA as seen on the bus |
| sda_pull | output | 1 | When 1, the pad pulls SDA low (open drain) |
| ctl_word | output | 117 | All 13 registers packed per R10 |

## Verification
Two updates can land in the same clock cycle. A mirrored write on a paired volume register stores one word into two slots at once. A software-reset write returns all thirteen slots to their defaults in one cycle. Both are provoked from both ports: SPI sweeps flip data bit 8 across the paired addresses, and explicit I2C writes set it. Each is judged by comparing the whole packed output word with a bench model that applies the same write in a single step. That comparison also shows that no neighbouring slot was disturbed.

// File: rtl/codec_ctl_pkg.sv
package codec_ctl_pkg;
  localparam int ADDR_W    = 7;
  localparam int DATA_W    = 9;
  localparam int FRAME_W   = ADDR_W + DATA_W;
  localparam int NSLOT     = 13;
  localparam int SLOT_W    = $clog2(NSLOT);
  localparam int LOW_LAST  = 9;
  localparam int HIGH_BASE = 16;
  localparam int HIGH_LAST = 18;
  localparam int PAIR_LAST = 3;
  localparam logic [ADDR_W-1:0] SRST_ADDR = ADDR_W'(15);
  localparam logic [6:0]        DEV_BASE  = 7'b0011010;

  typedef struct packed {
    logic              en;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_req_t;

  function automatic logic slot_valid(logic [ADDR_W-1:0] a);
    return (a <= ADDR_W'(LOW_LAST)) ||
           ((a >= ADDR_W'(HIGH_BASE)) && (a <= ADDR_W'(HIGH_LAST)));
  endfunction

  function automatic logic [SLOT_W-1:0] slot_of(logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] t;
    if (a <= ADDR_W'(LOW_LAST)) t = a;
    else t = a - ADDR_W'(HIGH_BASE) + ADDR_W'(LOW_LAST + 1);
    return t[SLOT_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] slot_default(int s);
    case (s)
      0, 1:    return DATA_W'(9'h097);
      2, 3:    return DATA_W'(9'h079);
      4:       return DATA_W'(9'h00A);
      5:       return DATA_W'(9'h008);
      6:       return DATA_W'(9'h09F);
      7:       return DATA_W'(9'h00A);
      10:      return DATA_W'(9'h07B);
      11:      return DATA_W'(9'h032);
      default: return '0;
    endcase
  endfunction

  function automatic logic [NSLOT*DATA_W-1:0] default_word();
    logic [NSLOT*DATA_W-1:0] w;
    for (int s = 0; s < NSLOT; s++) w[s*DATA_W +: DATA_W] = slot_default(s);
    return w;
  endfunction
endpackage

// File: rtl/ctl_pin_sync.sv
module ctl_pin_sync #(
  parameter int             W       = 4,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= RST_VAL;
    end else begin
      st_q[0] <= d;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/ctl_spi_rx.sv
module ctl_spi_rx import codec_ctl_pkg::*; (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en,
  input  logic    sck,
  input  logic    sdi,
  input  logic    csel,
  output wr_req_t req
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(FRAME_W);

  logic               sck_q, cs_q;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  wr_req_t            req_q, req_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    req_d = '0;
    if (!en) begin
      cnt_d = '0;
    end else begin
      if (!csel && sck && !sck_q) begin
        sh_d = {sh_q[FRAME_W-2:0], sdi};
        if (cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;
      end
      if (csel && !cs_q) begin
        if (cnt_q == CNT_END) begin
          req_d.en   = 1'b1;
          req_d.addr = sh_q[FRAME_W-1 -: ADDR_W];
          req_d.data = sh_q[DATA_W-1:0];
        end
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b1;
      cs_q  <= 1'b1;
      sh_q  <= '0;
      cnt_q <= '0;
      req_q <= '0;
    end else begin
      sck_q <= sck;
      cs_q  <= csel;
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign req = req_q;
endmodule

// File: rtl/ctl_i2c_slave.sv
module ctl_i2c_slave import codec_ctl_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              scl,
  input  logic              sda,
  input  logic              sel,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output wr_req_t           req,
  output logic              sda_pull
);
  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_TXACK, S_SKIP} st_t;
  typedef enum logic [1:0] {P_DEV, P_REG, P_DAT} ph_t;

  st_t               st_q, st_d;
  ph_t               ph_q, ph_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [7:0]        sh_q, sh_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              hib_q, hib_d;
  logic              rw_q, rw_d;
  logic              rdhi_q, rdhi_d;
  logic              txb_q, txb_d;
  logic              mack_q, mack_d;
  logic              pull_q, pull_d;
  logic              scl_q, sda_q;
  wr_req_t           req_q, req_d;
  logic              start_c, stop_c, rise_c, fall_c;

  assign start_c = scl && scl_q && sda_q && !sda;
  assign stop_c  = scl && scl_q && !sda_q && sda;
  assign rise_c  = scl && !scl_q;
  assign fall_c  = !scl && scl_q;

  always_comb begin
    st_d = st_q;  ph_d = ph_q;  cnt_d = cnt_q;  sh_d = sh_q;
    ptr_d = ptr_q;  hib_d = hib_q;  rw_d = rw_q;  rdhi_d = rdhi_q;
    txb_d = txb_q;  mack_d = mack_q;  pull_d = pull_q;
    req_d = '0;
    if (!en) begin
      st_d = S_IDLE;  pull_d = 1'b0;
    end else if (start_c) begin
      st_d = S_RX;  ph_d = P_DEV;  cnt_d = '0;  pull_d = 1'b0;
    end else if (stop_c) begin
      st_d = S_IDLE;  pull_d = 1'b0;
    end else begin
      case (st_q)
        S_RX: begin
          if (rise_c) begin
            sh_d  = {sh_q[6:0], sda};
            cnt_d = cnt_q + 1'b1;
          end else if (fall_c && cnt_q == 4'd8) begin
            case (ph_q)
              P_DEV: begin
                if (sh_q[7:1] == {DEV_BASE[6:1], sel}) begin
                  rw_d = sh_q[0];  pull_d = 1'b1;  st_d = S_ACK;
                end else begin
                  st_d = S_SKIP;
                end
              end
              P_REG: begin
                ptr_d = sh_q[7:1];  hib_d = sh_q[0];
                pull_d = 1'b1;  st_d = S_ACK;
              end
              default: begin
                req_d.en   = 1'b1;
                req_d.addr = ptr_q;
                req_d.data = {hib_q, sh_q};
                pull_d = 1'b1;  st_d = S_ACK;
              end
            endcase
          end
        end
        S_ACK: begin
          if (fall_c) begin
            pull_d = 1'b0;  cnt_d = '0;
            case (ph_q)
              P_DEV: begin
                if (rw_q) begin
                  pull_d = ~rd_data[7];
                  sh_d   = {rd_data[6:0], 1'b0};
                  rdhi_d = rd_data[DATA_W-1];
                  txb_d  = 1'b0;  cnt_d = 4'd1;  st_d = S_TX;
                end else begin
                  ph_d = P_REG;  st_d = S_RX;
                end
              end
              P_REG:   begin ph_d = P_DAT;  st_d = S_RX; end
              default: st_d = S_SKIP;
            endcase
          end
        end
        S_TX: begin
          if (fall_c) begin
            if (cnt_q == 4'd8) begin
              pull_d = 1'b0;  st_d = S_TXACK;
            end else begin
              pull_d = ~sh_q[7];
              sh_d   = {sh_q[6:0], 1'b0};
              cnt_d  = cnt_q + 1'b1;
            end
          end
        end
        S_TXACK: begin
          if (rise_c) begin
            mack_d = !sda;
          end else if (fall_c) begin
            if (mack_q && !txb_q) begin
              pull_d = 1'b1;
              sh_d   = {6'b0, rdhi_q, 1'b0};
              txb_d  = 1'b1;  cnt_d = 4'd1;  st_d = S_TX;
            end else begin
              st_d = S_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;  ph_q <= P_DEV;  cnt_q <= '0;  sh_q <= '0;
      ptr_q <= '0;  hib_q <= 1'b0;  rw_q <= 1'b0;  rdhi_q <= 1'b0;
      txb_q <= 1'b0;  mack_q <= 1'b0;  pull_q <= 1'b0;
      scl_q <= 1'b1;  sda_q <= 1'b1;  req_q <= '0;
    end else begin
      st_q <= st_d;  ph_q <= ph_d;  cnt_q <= cnt_d;  sh_q <= sh_d;
      ptr_q <= ptr_d;  hib_q <= hib_d;  rw_q <= rw_d;  rdhi_q <= rdhi_d;
      txb_q <= txb_d;  mack_q <= mack_d;  pull_q <= pull_d;
      scl_q <= scl;  sda_q <= sda;  req_q <= req_d;
    end
  end

  assign rd_addr  = ptr_q;
  assign req      = req_q;
  assign sda_pull = pull_q;
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank import codec_ctl_pkg::*; (
  input  logic                    clk,
  input  logic                    rst_n,
  input  wr_req_t                 req,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [DATA_W-1:0]       rd_data,
  output logic [NSLOT*DATA_W-1:0] ctl_word
);
  logic srst_c, pair_c;
  logic [SLOT_W-1:0] rd_idx;

  assign srst_c = req.en && (req.addr == SRST_ADDR);
  assign pair_c = req.en && (req.addr <= ADDR_W'(PAIR_LAST)) && req.data[DATA_W-1];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [DATA_W-1:0] val_q, val_d;
    logic              hit_c, mir_c;

    always_comb begin
      hit_c = req.en && slot_valid(req.addr) && (slot_of(req.addr) == SLOT_W'(s));
      mir_c = pair_c && (slot_of(req.addr ^ ADDR_W'(1)) == SLOT_W'(s));
      val_d = val_q;
      if (srst_c)             val_d = slot_default(s);
      else if (hit_c || mir_c) val_d = req.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= slot_default(s);
      else        val_q <= val_d;
    end

    assign ctl_word[s*DATA_W +: DATA_W] = val_q;
  end

  assign rd_idx  = slot_valid(rd_addr) ? slot_of(rd_addr) : '0;
  assign rd_data = slot_valid(rd_addr) ? ctl_word[rd_idx*DATA_W +: DATA_W] : '0;
endmodule

// File: rtl/codec_ctl_regs.sv
module codec_ctl_regs import codec_ctl_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    if_mode,
  input  logic                    csel,
  input  logic                    sck,
  input  logic                    sdi,
  output logic                    sda_pull,
  output logic [NSLOT*DATA_W-1:0] ctl_word
);
  logic [1:0]        rst_q;
  logic              rst_sync_n;
  logic [3:0]        pin_s;
  logic              mode_s, csel_s, sck_s, sdi_s;
  wr_req_t           spi_req, i2c_req, wr_req;
  logic              spi_wr, i2c_wr;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              i2c_pull;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  ctl_pin_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1111)) u_sync (
    .clk(clk), .rst_n(rst_sync_n),
    .d({if_mode, csel, sck, sdi}), .q(pin_s)
  );
  assign {mode_s, csel_s, sck_s, sdi_s} = pin_s;

  ctl_spi_rx u_spi (
    .clk(clk), .rst_n(rst_sync_n), .en(mode_s),
    .sck(sck_s), .sdi(sdi_s), .csel(csel_s), .req(spi_req)
  );

  ctl_i2c_slave u_i2c (
    .clk(clk), .rst_n(rst_sync_n), .en(!mode_s),
    .scl(sck_s), .sda(sdi_s), .sel(csel_s),
    .rd_data(rd_data), .rd_addr(rd_addr), .req(i2c_req), .sda_pull(i2c_pull)
  );

  assign spi_wr    = spi_req.en;
  assign i2c_wr    = i2c_req.en;
  assign wr_req.en = spi_wr | i2c_wr;
  assign wr_req.addr = spi_wr ? spi_req.addr : i2c_req.addr;
  assign wr_req.data = spi_wr ? spi_req.data : i2c_req.data;
  assign sda_pull  = i2c_pull & ~if_mode;

  ctl_reg_bank u_bank (
    .clk(clk), .rst_n(rst_sync_n), .req(wr_req),
    .rd_addr(rd_addr), .rd_data(rd_data), .ctl_word(ctl_word)
  );
endmodule

// File: rtl/codec_ctl_chk.sv
module codec_ctl_chk import codec_ctl_pkg::*; (
  input logic                    clk,
  input logic                    rst_n,
  input wr_req_t                 wr_req,
  input logic                    spi_wr,
  input logic                    i2c_wr,
  input logic [NSLOT*DATA_W-1:0] ctl_word
);
  logic [DATA_W-1:0] cur [NSLOT];
  logic              mapped, pair;
  logic [SLOT_W-1:0] w_slot;

  always_comb begin
    for (int s = 0; s < NSLOT; s++) cur[s] = ctl_word[s*DATA_W +: DATA_W];
  end

  assign mapped = slot_valid(wr_req.addr);
  assign w_slot = mapped ? slot_of(wr_req.addr) : '0;
  assign pair   = (wr_req.addr <= ADDR_W'(PAIR_LAST)) && wr_req.data[DATA_W-1];

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({spi_wr, i2c_wr})); // R1

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req.en && mapped |=> cur[$past(w_slot)] == $past(wr_req.data)); // R2

  AST_SRST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req.en && (wr_req.addr == SRST_ADDR) |=> ctl_word == default_word()); // R7

  AST_PAIR_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req.en && pair |=>
      cur[SLOT_W'($past(wr_req.addr[1:0]) ^ 2'd1)] == $past(wr_req.data)); // R8

  AST_UNMAPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req.en && !mapped && (wr_req.addr != SRST_ADDR) |=> $stable(ctl_word)); // R9
endmodule

bind codec_ctl_regs codec_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_req(wr_req),
  .spi_wr(spi_wr), .i2c_wr(i2c_wr), .ctl_word(ctl_word)
);

// File: tb/sim_codec_ctl_regs.sv
module sim_codec_ctl_regs;
  localparam int NS = 13;
  localparam int DW = 9;

  logic clk = 1'b0;
  logic rst_n, if_mode, csel, scl_m, sda_m;
  logic sda_pull;
  logic [NS*DW-1:0] ctl_word;
  wire  sdi_w = sda_m & ~sda_pull;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic pull_bad = 1'b0;
  logic [8:0] mdl [128];

  always #5 clk = ~clk;

  codec_ctl_regs u0 (
    .clk(clk), .rst_n(rst_n), .if_mode(if_mode), .csel(csel),
    .sck(scl_m), .sdi(sdi_w), .sda_pull(sda_pull), .ctl_word(ctl_word)
  );

  always @(negedge clk) if (if_mode && sda_pull) pull_bad = 1'b1;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask
  task automatic q(); tick(5); endtask

  function automatic bit mapped(input int a);
    return (a <= 9) || (a >= 16 && a <= 18);
  endfunction

  task automatic mdl_reset();
    for (int a = 0; a < 128; a++) mdl[a] = '0;
    mdl[0] = 9'h097; mdl[1] = 9'h097; mdl[2] = 9'h079; mdl[3] = 9'h079;
    mdl[4] = 9'h00A; mdl[5] = 9'h008; mdl[6] = 9'h09F; mdl[7] = 9'h00A;
    mdl[16] = 9'h07B; mdl[17] = 9'h032;
  endtask

  task automatic mdl_write(input int a, input logic [8:0] d);
    if (a == 15) mdl_reset();
    else if (mapped(a)) begin
      mdl[a] = d;
      if (a <= 3 && d[8]) mdl[a ^ 1] = d;
    end
  endtask

  task automatic chk_word(input string tag);
    logic [NS*DW-1:0] e;
    for (int s = 0; s < NS; s++) e[s*DW +: DW] = mdl[(s < 10) ? s : s + 6];
    n_chk++;
    if (ctl_word !== e) begin
      n_fail++;
      $display("FAIL %s R10 word: actual %h expected %h", tag, ctl_word, e);
    end
  endtask

  task automatic chk_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic spi_frame(input logic [15:0] w, input int nbits);
    csel = 1'b0; scl_m = 1'b0; q();
    for (int i = 0; i < nbits; i++) begin
      scl_m = 1'b0; sda_m = w[15-i]; q();
      scl_m = 1'b1; q();
    end
    scl_m = 1'b0; q();
    csel = 1'b1; tick(8);
  endtask

  task automatic i2c_start(); sda_m = 1'b1; scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q(); endtask
  task automatic i2c_rstart(); scl_m = 1'b0; sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q(); endtask
  task automatic i2c_stop(); sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q(); tick(6); endtask

  task automatic i2c_wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q(); scl_m = 1'b1; q(); scl_m = 1'b0;
    end
    q(); sda_m = 1'b1; q(); scl_m = 1'b1; q();
    ack = !sdi_w; scl_m = 1'b0; q();
  endtask

  task automatic i2c_rbyte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      q(); scl_m = 1'b1; q(); b = {b[6:0], sdi_w}; scl_m = 1'b0;
    end
    q(); sda_m = !mack; q(); scl_m = 1'b1; q(); scl_m = 1'b0; q(); sda_m = 1'b1;
  endtask

  task automatic i2c_wr(input logic [6:0] dev, input logic [6:0] a, input logic [8:0] d,
                        input bit extra, output logic [3:0] acks);
    acks = '0;
    i2c_start();
    i2c_wbyte({dev, 1'b0}, acks[0]);
    i2c_wbyte({a, d[8]}, acks[1]);
    i2c_wbyte(d[7:0], acks[2]);
    if (extra) i2c_wbyte(8'h5A, acks[3]);
    i2c_stop();
  endtask

  task automatic i2c_rd(input logic [6:0] dev, input logic [6:0] a, output logic [15:0] r);
    logic ak; logic [7:0] lo, hi;
    i2c_start();
    i2c_wbyte({dev, 1'b0}, ak);
    i2c_wbyte({a, 1'b0}, ak);
    i2c_rstart();
    i2c_wbyte({dev, 1'b1}, ak);
    i2c_rbyte(1'b1, lo);
    i2c_rbyte(1'b0, hi);
    i2c_stop();
    r = {hi, lo};
  endtask

  initial begin
    logic [3:0] acks;
    logic [15:0] rv;
    logic [8:0] d;
    rst_n = 1'b0; if_mode = 1'b1; csel = 1'b1; scl_m = 1'b1; sda_m = 1'b1;
    mdl_reset();
    tick(5); rst_n = 1'b1; tick(10);

    chk_word("R6 reset defaults");
    chk_val("R1 line released after reset", 32'(sda_pull), 32'd0);

    for (int pass = 0; pass < 2; pass++) begin
      for (int a = 0; a < 128; a++) begin
        d = 9'((a * 37 + 5) & 511);
        if (pass == 1) d = ~d;
        spi_frame({7'(a), d}, 16);
        mdl_write(a, d);
        if (a == 15)                 chk_word("R7 SPI soft reset");
        else if (a <= 3 && d[8])     chk_word("R8 SPI paired write");
        else if (!mapped(a))         chk_word("R9 SPI unmapped write dropped");
        else                         chk_word("R2 SPI write");
      end
    end

    spi_frame({7'h04, 9'h155}, 15);
    chk_word("R2 short SPI frame discarded");
    spi_frame({7'h02, 9'h1A5}, 16); mdl_write(2, 9'h1A5);
    chk_word("R8 SPI pair 2 to 3");
    spi_frame({7'h03, 9'h033}, 16); mdl_write(3, 9'h033);
    chk_word("R8 SPI bit8 clear only 3");
    chk_val("R1 no SDA pull in SPI mode", 32'(pull_bad), 32'd0);

    if_mode = 1'b0; csel = 1'b0; tick(10);
    spi_frame({7'h05, 9'h1FF}, 16);
    csel = 1'b0; tick(10);
    chk_word("R1 SPI frame ignored in I2C mode");

    i2c_wr(7'b0011010, 7'h05, 9'h0F3, 1'b0, acks); mdl_write(5, 9'h0F3);
    chk_val("R3 R4 acks addr low", 32'(acks[2:0]), 32'h7);
    chk_word("R4 I2C write");
    i2c_wr(7'b0011011, 7'h05, 9'h011, 1'b0, acks);
    chk_val("R3 wrong device no ack", 32'(acks[2:0]), 32'h0);
    chk_word("R3 wrong device no change");

    csel = 1'b1; tick(10);
    i2c_wr(7'b0011011, 7'h11, 9'h1C4, 1'b0, acks); mdl_write(17, 9'h1C4);
    chk_val("R3 acks addr high", 32'(acks[2:0]), 32'h7);
    chk_word("R3 R4 I2C write high select");
    i2c_wr(7'b0011010, 7'h11, 9'h000, 1'b0, acks);
    chk_val("R3 low address rejected", 32'(acks[2:0]), 32'h0);
    chk_word("R3 low address no change");

    i2c_wr(7'b0011011, 7'h01, 9'h155, 1'b0, acks); mdl_write(1, 9'h155);
    chk_word("R8 I2C pair 1 to 0");
    i2c_wr(7'b0011011, 7'h07, 9'h0C3, 1'b1, acks); mdl_write(7, 9'h0C3);
    chk_val("R4 fourth byte not acked", 32'(acks), 32'h7);
    chk_word("R4 extra byte no effect");
    i2c_wr(7'b0011011, 7'h0F, 9'h1AB, 1'b0, acks); mdl_write(15, 9'h1AB);
    chk_word("R7 I2C soft reset");
    i2c_wr(7'b0011011, 7'h06, 9'h1E1, 1'b0, acks); mdl_write(6, 9'h1E1);
    i2c_wr(7'b0011011, 7'h12, 9'h10C, 1'b0, acks); mdl_write(18, 9'h10C);
    i2c_wr(7'b0011011, 7'h40, 9'h0AA, 1'b0, acks);
    chk_word("R9 I2C unmapped write dropped");

    for (int a = 0; a < 19; a++) begin
      if (mapped(a)) begin
        i2c_rd(7'b0011011, 7'(a), rv);
        chk_val("R5 I2C read", 32'(rv), 32'({7'b0, mdl[a][8], mdl[a][7:0]}));
      end
    end
    i2c_rd(7'b0011011, 7'h0A, rv); chk_val("R9 read 0x0A", 32'(rv), 32'd0);
    i2c_rd(7'b0011011, 7'h0F, rv); chk_val("R9 read 0x0F", 32'(rv), 32'd0);
    i2c_rd(7'b0011011, 7'h13, rv); chk_val("R9 read 0x13", 32'(rv), 32'd0);
    i2c_rd(7'b0011011, 7'h7F, rv); chk_val("R9 read 0x7F", 32'(rv), 32'd0);

    if_mode = 1'b1; tick(10);
    i2c_wr(7'b0011011, 7'h04, 9'h1FF, 1'b0, acks);
    chk_val("R1 I2C ignored in SPI mode acks", 32'(acks[2:0]), 32'h0);
    chk_word("R1 I2C ignored in SPI mode");
    chk_val("R1 no SDA pull in SPI mode end", 32'(pull_bad), 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule